// File: doc/BRIEF.md
# Two-Level Speculative Branch Tracker

This block follows at most two unresolved conditional branches in a pipeline that dispatches in order. When a branch is dispatched before its condition is known, the front end predicts its direction. It then tells the tracker the predicted direction, the address of the path not taken, and the completion-queue slot the branch occupies. The tracker keeps these as a record. It then tells the rest of the pipeline what the instructions on the newest predicted path may do. Under one open branch, those instructions may execute but may not complete past the branch's slot. Under two open branches, the newest path may only be fetched. A third branch holds dispatch until a resolution frees a level.

Resolutions always refer to the oldest open branch and arrive marked correct or mispredicted. A correct resolution retires the oldest record and promotes the younger one, so its path gains execute rights. A misprediction drops both records. One cycle later it raises a flush for exactly one cycle. The flush command carries the mispredicted branch's completion-queue slot as the boundary: everything younger is purged from the instruction queue, the completion queue and the rename registers. It also carries the alternate-path address where fetch restarts. When the completion queue is full, dispatch is held regardless of the speculation level.

Control is a four-state machine. IDLE means no branch is open. LVL1 means one branch is open. LVL2 means two are open. RECOVER is the single flush cycle. The transitions are:
- IDLE→LVL1 on an accepted dispatch.
- LVL1→LVL2 on a dispatch with no resolution.
- LVL1→IDLE on a correct resolution without a dispatch.
- LVL1→LVL1 on a correct resolution together with a dispatch.
- LVL2→LVL1 on a correct resolution without a dispatch.
- LVL2→LVL2 on a correct resolution together with a dispatch.
- LVL1 or LVL2→RECOVER on a misprediction.
- RECOVER→IDLE always.

Top module: `spb_tracker`

## Requirements
- R1: After reset, spec_depth is 0 and disp_stall, flush_valid and cmpl_block are 0. path_may_exec is 1.
- R2: A dispatch accepted with no branch open gives spec_depth 1 on the next cycle. It also raises cmpl_block with cmpl_bound_idx equal to that branch's slot, and path_may_exec stays 1.
- R3: A dispatch accepted with one branch open gives spec_depth 2 on the next cycle. It also raises fetch_only with fetch_bound_idx equal to the new branch's slot, and path_may_exec is 0.
- R4: At spec_depth 2, disp_stall is 1 unless a correct resolution is presented in the same cycle. A dispatch presented while disp_stall is 1 is ignored.
- R5: While cq_full is 1, disp_stall is 1 and any dispatch is ignored.
- R6: A correct resolution at spec_depth 2 leaves spec_depth 1 with cmpl_bound_idx equal to the younger branch's slot, and path_may_exec returns to 1.
- R7: A misprediction at spec_depth 1 or 2 sets flush_valid in the next cycle, for exactly one cycle. In that cycle flush_cq_idx is the oldest branch's slot and redirect_addr is its alternate address. spec_depth is 0 from then on.
- R8: During the flush cycle, disp_stall is 1, path_may_exec is 0, and resolutions and dispatches are ignored.
- R9: When a resolution and a dispatch arrive together, the resolution is applied first. After a correct resolution the dispatch takes the freed level. After a misprediction the dispatch is discarded.
- R10: A resolution presented while spec_depth is 0 has no effect.
- R11: While spec_depth is at least 1, head_pred_taken equals the predicted direction recorded for the oldest open branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_disp_valid | input | 1 | A predicted branch is being dispatched |
| br_disp_pred_taken | input | 1 | Predicted direction of that branch |
| br_disp_alt_addr | input | AW | Address of the path not predicted |
| br_disp_cq_idx | input | IW | Completion-queue slot of the branch |
| rslv_valid | input | 1 | Oldest open branch resolves this cycle |
| rslv_mispred | input | 1 | 1 = the resolution is a misprediction |
| cq_full | input | 1 | Completion queue has no free slot |
| disp_stall | output | 1 | Front end must hold dispatch |
| spec_depth | output | 2 | Number of open branches (0, 1 or 2) |
| path_may_exec | output | 1 | Newest-path instructions may execute |
| fetch_only | output | 1 | Newest path may be fetched but not executed |
| cmpl_block | output | 1 | Completion is blocked past cmpl_bound_idx |
| cmpl_bound_idx | output | IW | Slot of the oldest open branch |
| fetch_bound_idx | output | IW | Slot of the younger open branch |
| head_pred_taken | output | 1 | Predicted direction of the oldest open branch |
| flush_valid | output | 1 | One-cycle flush and redirect command |
| flush_cq_idx | output | IW | Flush everything younger than this slot |
| redirect_addr | output | AW | Fetch restart address |

## Verification
The interesting collision is a resolution and a new dispatch in the same cycle, combined with a full completion queue and with each starting level, including the flush cycle. The bench starts from each of the four states and applies all sixteen combinations of dispatch, resolve, mispredict and queue-full. It then runs a long pseudo-random stream. A bench-side model applies resolution before dispatch and predicts the next depth, the boundary slots and the flush fields. The combinational stall is judged inside the cycle, and the registered outputs shortly after the following edge.

// File: rtl/spb_pkg.sv
package spb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_LVL1    = 2'd1,
        ST_LVL2    = 2'd2,
        ST_RECOVER = 2'd3
    } spb_state_e;
endpackage

// File: rtl/spb_rec_queue.sv
// Age-ordered store of open-branch records; slot 0 is the oldest.
module spb_rec_queue #(
    parameter int AW = 32,
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pop,
    input  logic          clear,
    input  logic          push,
    input  logic          push_pred,
    input  logic [AW-1:0] push_addr,
    input  logic [IW-1:0] push_idx,
    output logic          head_pred,
    output logic [AW-1:0] head_addr,
    output logic [IW-1:0] head_idx,
    output logic [IW-1:0] next_idx
);
    localparam int NREC = 2;

    logic          v_q    [NREC];
    logic          pred_q [NREC];
    logic [AW-1:0] addr_q [NREC];
    logic [IW-1:0] idx_q  [NREC];
    logic          v_d    [NREC];
    logic          pred_d [NREC];
    logic [AW-1:0] addr_d [NREC];
    logic [IW-1:0] idx_d  [NREC];

    always_comb begin
        logic placed;
        placed = 1'b0;
        for (int i = 0; i < NREC; i++) begin
            v_d[i]    = v_q[i];
            pred_d[i] = pred_q[i];
            addr_d[i] = addr_q[i];
            idx_d[i]  = idx_q[i];
        end
        if (clear) begin
            for (int i = 0; i < NREC; i++) v_d[i] = 1'b0;
        end else begin
            // resolution is applied before the new record is placed
            if (pop) begin
                for (int i = 0; i < NREC - 1; i++) begin
                    v_d[i]    = v_q[i+1];
                    pred_d[i] = pred_q[i+1];
                    addr_d[i] = addr_q[i+1];
                    idx_d[i]  = idx_q[i+1];
                end
                v_d[NREC-1] = 1'b0;
            end
            if (push) begin
                for (int i = 0; i < NREC; i++) begin
                    if (!placed && !v_d[i]) begin
                        v_d[i]    = 1'b1;
                        pred_d[i] = push_pred;
                        addr_d[i] = push_addr;
                        idx_d[i]  = push_idx;
                        placed    = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREC; i++) begin
                v_q[i]    <= 1'b0;
                pred_q[i] <= 1'b0;
                addr_q[i] <= '0;
                idx_q[i]  <= '0;
            end
        end else begin
            for (int i = 0; i < NREC; i++) begin
                v_q[i]    <= v_d[i];
                pred_q[i] <= pred_d[i];
                addr_q[i] <= addr_d[i];
                idx_q[i]  <= idx_d[i];
            end
        end
    end

    assign head_pred = pred_q[0];
    assign head_addr = addr_q[0];
    assign head_idx  = idx_q[0];
    assign next_idx  = idx_q[1];
endmodule

// File: rtl/spb_fsm.sv
// Speculation-level state machine: decides stall, push, pop and flush.
module spb_fsm
    import spb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       br_disp_valid,
    input  logic       rslv_valid,
    input  logic       rslv_mispred,
    input  logic       cq_full,
    output spb_state_e state_q,
    output logic       q_pop,
    output logic       q_clear,
    output logic       q_push,
    output logic       flush_cap,
    output logic       disp_stall
);
    spb_state_e state_d;
    logic       open_lvl;
    logic       res_ok;
    logic       res_bad;

    always_comb begin
        open_lvl = (state_q == ST_LVL1) || (state_q == ST_LVL2);
        res_ok   = open_lvl && rslv_valid && !rslv_mispred;
        res_bad  = open_lvl && rslv_valid && rslv_mispred;
    end

    // output process
    always_comb begin
        disp_stall = cq_full;
        unique case (state_q)
            ST_IDLE:    disp_stall = cq_full;
            ST_LVL1:    disp_stall = cq_full;
            ST_LVL2:    disp_stall = cq_full || !res_ok;
            ST_RECOVER: disp_stall = 1'b1;
        endcase
        q_push    = br_disp_valid && !disp_stall && !res_bad;
        q_pop     = res_ok;
        q_clear   = res_bad;
        flush_cap = res_bad;
    end

    // next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (q_push) state_d = ST_LVL1;
            end
            ST_LVL1: begin
                if (res_bad)      state_d = ST_RECOVER;
                else if (res_ok)  state_d = q_push ? ST_LVL1 : ST_IDLE;
                else if (q_push)  state_d = ST_LVL2;
            end
            ST_LVL2: begin
                if (res_bad)      state_d = ST_RECOVER;
                else if (res_ok)  state_d = q_push ? ST_LVL2 : ST_LVL1;
            end
            ST_RECOVER: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/spb_flush_reg.sv
// Holds the flush boundary and restart address captured at a misprediction.
module spb_flush_reg #(
    parameter int AW = 32,
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap,
    input  logic [IW-1:0] cap_idx,
    input  logic [AW-1:0] cap_addr,
    output logic [IW-1:0] flush_cq_idx,
    output logic [AW-1:0] redirect_addr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flush_cq_idx  <= '0;
            redirect_addr <= '0;
        end else if (cap) begin
            flush_cq_idx  <= cap_idx;
            redirect_addr <= cap_addr;
        end
    end
endmodule

// File: rtl/spb_tracker.sv
module spb_tracker
    import spb_pkg::*;
#(
    parameter int AW = 32,
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          br_disp_valid,
    input  logic          br_disp_pred_taken,
    input  logic [AW-1:0] br_disp_alt_addr,
    input  logic [IW-1:0] br_disp_cq_idx,
    input  logic          rslv_valid,
    input  logic          rslv_mispred,
    input  logic          cq_full,
    output logic          disp_stall,
    output logic [1:0]    spec_depth,
    output logic          path_may_exec,
    output logic          fetch_only,
    output logic          cmpl_block,
    output logic [IW-1:0] cmpl_bound_idx,
    output logic [IW-1:0] fetch_bound_idx,
    output logic          head_pred_taken,
    output logic          flush_valid,
    output logic [IW-1:0] flush_cq_idx,
    output logic [AW-1:0] redirect_addr
);
    spb_state_e    state_q;
    logic          q_pop, q_clear, q_push, flush_cap;
    logic          hd_pred;
    logic [AW-1:0] hd_addr;
    logic [IW-1:0] hd_idx, nx_idx;

    spb_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .br_disp_valid(br_disp_valid),
        .rslv_valid   (rslv_valid),
        .rslv_mispred (rslv_mispred),
        .cq_full      (cq_full),
        .state_q      (state_q),
        .q_pop        (q_pop),
        .q_clear      (q_clear),
        .q_push       (q_push),
        .flush_cap    (flush_cap),
        .disp_stall   (disp_stall)
    );

    spb_rec_queue #(.AW(AW), .IW(IW)) u_recs (
        .clk      (clk),
        .rst_n    (rst_n),
        .pop      (q_pop),
        .clear    (q_clear),
        .push     (q_push),
        .push_pred(br_disp_pred_taken),
        .push_addr(br_disp_alt_addr),
        .push_idx (br_disp_cq_idx),
        .head_pred(hd_pred),
        .head_addr(hd_addr),
        .head_idx (hd_idx),
        .next_idx (nx_idx)
    );

    spb_flush_reg #(.AW(AW), .IW(IW)) u_flush (
        .clk          (clk),
        .rst_n        (rst_n),
        .cap          (flush_cap),
        .cap_idx      (hd_idx),
        .cap_addr     (hd_addr),
        .flush_cq_idx (flush_cq_idx),
        .redirect_addr(redirect_addr)
    );

    // permissions per speculation level
    always_comb begin
        spec_depth    = 2'd0;
        path_may_exec = 1'b1;
        fetch_only    = 1'b0;
        cmpl_block    = 1'b0;
        flush_valid   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                spec_depth = 2'd0;
            end
            ST_LVL1: begin
                spec_depth = 2'd1;
                cmpl_block = 1'b1;
            end
            ST_LVL2: begin
                spec_depth    = 2'd2;
                cmpl_block    = 1'b1;
                fetch_only    = 1'b1;
                path_may_exec = 1'b0;
            end
            ST_RECOVER: begin
                path_may_exec = 1'b0;
                flush_valid   = 1'b1;
            end
        endcase
        cmpl_bound_idx  = hd_idx;
        fetch_bound_idx = nx_idx;
        head_pred_taken = hd_pred && cmpl_block;
    end
endmodule

// File: rtl/spb_tracker_chk.sv
module spb_tracker_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       br_disp_valid,
    input logic       rslv_valid,
    input logic       rslv_mispred,
    input logic       cq_full,
    input logic       disp_stall,
    input logic       fetch_only,
    input logic       flush_valid,
    input logic [1:0] spec_depth
);
    p_lvl2_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (spec_depth == 2'd2 && !(rslv_valid && !rslv_mispred)) |-> disp_stall);

    p_full_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cq_full |-> disp_stall);

    p_second_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (spec_depth == 2'd1 && br_disp_valid && !disp_stall && !rslv_valid) |=> fetch_only);

    p_promote_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (spec_depth == 2'd2 && rslv_valid && !rslv_mispred) |=> (spec_depth != 2'd0));

    p_flush_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (spec_depth != 2'd0 && rslv_valid && rslv_mispred) |=> flush_valid);

    p_flush_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |=> (!flush_valid && spec_depth == 2'd0));

    p_recover_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |-> disp_stall);

    p_idle_ignores_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (spec_depth == 2'd0 && !flush_valid && !br_disp_valid) |=> (spec_depth == 2'd0 && !flush_valid));
endmodule

bind spb_tracker spb_tracker_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .br_disp_valid(br_disp_valid),
    .rslv_valid   (rslv_valid),
    .rslv_mispred (rslv_mispred),
    .cq_full      (cq_full),
    .disp_stall   (disp_stall),
    .fetch_only   (fetch_only),
    .flush_valid  (flush_valid),
    .spec_depth   (spec_depth)
);

// File: tb/tb_spb_tracker.sv
`timescale 1ns/1ps
module tb_spb_tracker;
    localparam int AW = 32;
    localparam int IW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic br_disp_valid = 1'b0, br_disp_pred_taken = 1'b0;
    logic [AW-1:0] br_disp_alt_addr = '0;
    logic [IW-1:0] br_disp_cq_idx = '0;
    logic rslv_valid = 1'b0, rslv_mispred = 1'b0, cq_full = 1'b0;
    logic disp_stall, path_may_exec, fetch_only, cmpl_block, head_pred_taken, flush_valid;
    logic [1:0] spec_depth;
    logic [IW-1:0] cmpl_bound_idx, fetch_bound_idx, flush_cq_idx;
    logic [AW-1:0] redirect_addr;

    always #10 clk = ~clk;

    spb_tracker #(.AW(AW), .IW(IW)) dut (.*);

    int checks = 0, failures = 0;
    bit done = 0;

    // bench model
    int m_depth;
    bit m_rec;
    logic [IW-1:0] m_idx [2];
    logic [AW-1:0] m_addr [2];
    logic m_pred [2];
    logic [IW-1:0] m_fidx;
    logic [AW-1:0] m_faddr;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_regs(input string tag);
        chk(tag, "spec_depth", spec_depth, m_rec ? 0 : m_depth);
        chk("R7", "flush_valid", flush_valid, m_rec);
        if (m_rec) begin
            chk("R7", "flush_cq_idx", flush_cq_idx, m_fidx);
            chk("R7", "redirect_addr", redirect_addr, m_faddr);
        end
        chk(m_rec ? "R8" : "R3", "path_may_exec", path_may_exec, (!m_rec && m_depth < 2));
        chk("R3", "fetch_only", fetch_only, (!m_rec && m_depth == 2));
        chk("R2", "cmpl_block", cmpl_block, (!m_rec && m_depth >= 1));
        if (!m_rec && m_depth >= 1) begin
            chk("R6", "cmpl_bound_idx", cmpl_bound_idx, m_idx[0]);
            chk("R11", "head_pred_taken", head_pred_taken, m_pred[0]);
        end
        if (!m_rec && m_depth == 2)
            chk("R3", "fetch_bound_idx", fetch_bound_idx, m_idx[1]);
    endtask

    task automatic step(input bit dv, input bit dp, input logic [AW-1:0] da,
                        input logic [IW-1:0] di, input bit rv, input bit rm, input bit full);
        bit stall, ok, bad, push;
        string tag;
        @(negedge clk);
        br_disp_valid = dv; br_disp_pred_taken = dp; br_disp_alt_addr = da;
        br_disp_cq_idx = di; rslv_valid = rv; rslv_mispred = rm; cq_full = full;
        #2;
        stall = full || m_rec || (m_depth == 2 && !(rv && !rm));
        ok  = rv && !rm && m_depth > 0 && !m_rec;
        bad = rv && rm && m_depth > 0 && !m_rec;
        push = dv && !stall && !bad;
        if (m_rec)                    tag = "R8";
        else if (rv && m_depth == 0)  tag = "R10";
        else if (rv && dv)            tag = "R9";
        else if (ok && m_depth == 2)  tag = "R6";
        else if (full)                tag = "R5";
        else if (m_depth == 2)        tag = "R4";
        else                          tag = "R2";
        chk(full ? "R5" : (m_rec ? "R8" : "R4"), "disp_stall", disp_stall, stall);
        @(posedge clk);
        if (m_rec) begin
            m_rec = 0;
        end else if (bad) begin
            m_fidx = m_idx[0]; m_faddr = m_addr[0];
            m_depth = 0; m_rec = 1;
        end else begin
            if (ok) begin
                m_idx[0] = m_idx[1]; m_addr[0] = m_addr[1]; m_pred[0] = m_pred[1];
                m_depth--;
            end
            if (push) begin
                m_idx[m_depth] = di; m_addr[m_depth] = da; m_pred[m_depth] = dp;
                m_depth++;
            end
        end
        #5;
        check_regs(tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        br_disp_valid = 0; rslv_valid = 0; rslv_mispred = 0; cq_full = 0;
        m_depth = 0; m_rec = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        #2;
        chk("R1", "spec_depth", spec_depth, 0);
        chk("R1", "disp_stall", disp_stall, 0);
        chk("R1", "flush_valid", flush_valid, 0);
        chk("R1", "cmpl_block", cmpl_block, 0);
        chk("R1", "path_may_exec", path_may_exec, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        // sweep: every start state x every input combination
        for (int st = 0; st < 4; st++) begin
            for (int c = 0; c < 16; c++) begin
                do_reset();
                if (st >= 1) step(1, 1, 32'h100 + st, 3'(st + 1), 0, 0, 0);
                if (st >= 2) step(1, 0, 32'h200 + st, 3'(st + 4), 0, 0, 0);
                if (st == 3) step(0, 0, 0, 0, 1, 1, 0);
                step(c[0], c[0] ^ c[2], 32'h1000 + st * 256 + c * 4, 3'((st * 5 + c) % 8),
                     c[1], c[2], c[3]);
                step(0, 0, 0, 0, 0, 0, 0);
                step(0, 0, 0, 0, 0, 0, 0);
            end
        end
        // long pseudo-random stream
        do_reset();
        lfsr = 16'hACE1;
        for (int n = 0; n < 600; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0] | lfsr[5], lfsr[1], {16'h0, lfsr}, lfsr[4:2],
                 lfsr[6] & lfsr[7], lfsr[8] & lfsr[9] & lfsr[11], lfsr[12] & lfsr[13] & lfsr[14]);
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule